// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned or two's-complement operands together with an incoming carry, and produces the sum and the outgoing carry. No carry ripples from bit to bit. Each bit position first classifies itself. It generates a carry when both operand bits are 1, passes the incoming carry on when exactly one of them is 1, and kills the carry when both are 0. The bits are then gathered into fixed-size groups. Inside each group, sum-of-products lookahead equations produce the carry into every bit, along with a group-wide generate and propagate term. A second lookahead unit of the same form takes those group terms and produces the carry into every group at once.

The default build is a 16-bit adder made from four 4-bit groups. The adder also exports its own block generate and block propagate terms. A wider adder can therefore place another lookahead level above several copies of this block instead of chaining their carries. The operand width is the group width multiplied by the group count, and both are parameters.

Top module: `cla_adder_2lvl`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i`, where WIDTH = GROUP_W * GROUPS and the operands are read as unsigned numbers.
- R2: `cout_o` equals bit WIDTH, the carry out of the top bit, of `a_i + b_i + cin_i`.
- R3: `blk_prop_o` is 1 exactly when every bit pair of the operands differs, so that `a_i ^ b_i` is all ones.
- R4: `blk_gen_o` is 1 exactly when `a_i + b_i` alone, with no carry-in, carries out of bit WIDTH-1.
- R5: `cout_o` always equals `blk_gen_o | (blk_prop_o & cin_i)`, so the block can be cascaded through its generate and propagate outputs.
- R6: When every bit pair propagates, an incoming carry of 1 travels across the whole width. The sum is then all zeros and `cout_o` is 1, for example `a_i`=16'hFFFF, `b_i`=0, `cin_i`=1.
- R7: A carry arriving at a group boundary, with every lower bit propagating or generating, reaches the correct bit of the next group. For example, `a_i`=2^(4k)-1 plus `b_i`=1 sets only bit 4k.
- R8: The arithmetic of R1 to R5 holds for any group width and group count. This includes a configuration of two 2-bit groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | GROUP_W*GROUPS | First operand |
| b_i | input | GROUP_W*GROUPS | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | GROUP_W*GROUPS | Sum, modulo 2^WIDTH |
| cout_o | output | 1 | Carry out of the top bit |
| blk_gen_o | output | 1 | Whole-block generate term |
| blk_prop_o | output | 1 | Whole-block propagate term |

## Verification
The bench builds two copies of the adder. The first uses the default four 4-bit groups. The second uses two 2-bit groups, which gives a 4-bit adder. On the small copy all 512 combinations of operands and carry-in can be applied, so every generate, propagate and kill pattern at every bit and every group boundary is reached. On the 16-bit copy the bench applies directed corner cases: full-width propagation, a carry entering each group boundary, and alternating bit patterns. It also applies a few thousand random vectors. Every response is compared against plain integer addition.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned DEF_GROUP_W = 4;
  localparam int unsigned DEF_GROUPS  = 4;

  // Generate/propagate pair summarising one bit, one group or the whole block
  typedef struct packed {
    logic gen;
    logic prop;
  } gp_pair_t;

  // Carry leaving a span, given its summary pair and the carry entering it
  function automatic logic span_carry_out(input gp_pair_t gp, input logic c_in);
    return gp.gen | (gp.prop & c_in);
  endfunction

endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o
);

  // Each position: both ones generate, one one propagates, none kills
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen_o[i]  = a_i[i] & b_i[i];
    assign prop_o[i] = a_i[i] ^ b_i[i];
  end

endmodule

// File: rtl/cla_lookahead_unit.sv
module cla_lookahead_unit
  import cla_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N-1:0] carry_o,
  output gp_pair_t     blk_o
);

  // Flat sum of products for the carry entering position k:
  //   OR over j<k of gen[j] & prop[j+1..k-1], plus cin & prop[0..k-1]
  function automatic logic carry_into(input logic [N-1:0] g,
                                      input logic [N-1:0] p,
                                      input logic         c0,
                                      input int unsigned  k);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int unsigned j = 0; j < N; j++) begin
      if (j < k) begin
        term = g[j];
        for (int unsigned m = 0; m < N; m++) begin
          if (m > j && m < k) term = term & p[m];
        end
        acc = acc | term;
      end
    end
    term = c0;
    for (int unsigned m = 0; m < N; m++) begin
      if (m < k) term = term & p[m];
    end
    return acc | term;
  endfunction

  function automatic logic all_prop(input logic [N-1:0] p);
    return &p;
  endfunction

  for (genvar k = 0; k < N; k++) begin : g_carry
    assign carry_o[k] = carry_into(gen_i, prop_i, cin_i, k);
  end

  // Span generate is the carry out of position N-1 with no carry entering
  assign blk_o.gen  = carry_into(gen_i, prop_i, 1'b0, N);
  assign blk_o.prop = all_prop(prop_i);

endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          cin_i,
  output logic [GW-1:0] sum_o,
  output gp_pair_t      grp_o
);

  logic [GW-1:0] bit_gen;
  logic [GW-1:0] bit_prop;
  logic [GW-1:0] bit_carry;

  cla_bit_pg #(.W(GW)) pg_i (
    .a_i   (a_i),
    .b_i   (b_i),
    .gen_o (bit_gen),
    .prop_o(bit_prop)
  );

  cla_lookahead_unit #(.N(GW)) la_i (
    .gen_i  (bit_gen),
    .prop_i (bit_prop),
    .cin_i  (cin_i),
    .carry_o(bit_carry),
    .blk_o  (grp_o)
  );

  assign sum_o = bit_prop ^ bit_carry;

endmodule

// File: rtl/cla_adder_2lvl.sv
module cla_adder_2lvl
  import cla_pkg::*;
#(
  parameter int unsigned GROUP_W = DEF_GROUP_W,
  parameter int unsigned GROUPS  = DEF_GROUPS
) (
  input  logic [GROUP_W*GROUPS-1:0] a_i,
  input  logic [GROUP_W*GROUPS-1:0] b_i,
  input  logic                      cin_i,
  output logic [GROUP_W*GROUPS-1:0] sum_o,
  output logic                      cout_o,
  output logic                      blk_gen_o,
  output logic                      blk_prop_o
);

  localparam int unsigned WIDTH = GROUP_W * GROUPS;

  // Internal events brought out by name for the bound checker
  logic [GROUPS-1:0] grp_cin;
  logic [GROUPS-1:0] grp_gen;
  logic [GROUPS-1:0] grp_prop;
  gp_pair_t          top_pair;

  for (genvar k = 0; k < GROUPS; k++) begin : g_grp
    gp_pair_t pair_k;
    cla_group #(.GW(GROUP_W)) grp_i (
      .a_i  (a_i[k*GROUP_W +: GROUP_W]),
      .b_i  (b_i[k*GROUP_W +: GROUP_W]),
      .cin_i(grp_cin[k]),
      .sum_o(sum_o[k*GROUP_W +: GROUP_W]),
      .grp_o(pair_k)
    );
    assign grp_gen[k]  = pair_k.gen;
    assign grp_prop[k] = pair_k.prop;
  end

  // Second level: same equation form, over group terms
  cla_lookahead_unit #(.N(GROUPS)) top_la_i (
    .gen_i  (grp_gen),
    .prop_i (grp_prop),
    .cin_i  (cin_i),
    .carry_o(grp_cin),
    .blk_o  (top_pair)
  );

  assign blk_gen_o  = top_pair.gen;
  assign blk_prop_o = top_pair.prop;
  assign cout_o     = span_carry_out(top_pair, cin_i);

  if (WIDTH < 2) begin : g_width_guard
    initial $display("cla_adder_2lvl: width below two bits");
  end

endmodule

// File: rtl/cla_adder_2lvl_chk.sv
module cla_adder_2lvl_chk #(
  parameter int unsigned GROUP_W = 4,
  parameter int unsigned GROUPS  = 4
) (
  input logic [GROUP_W*GROUPS-1:0] a_i,
  input logic [GROUP_W*GROUPS-1:0] b_i,
  input logic                      cin_i,
  input logic [GROUP_W*GROUPS-1:0] sum_o,
  input logic                      cout_o,
  input logic                      blk_gen_o,
  input logic                      blk_prop_o,
  input logic [GROUPS-1:0]         grp_cin,
  input logic [GROUPS-1:0]         grp_gen,
  input logic [GROUPS-1:0]         grp_prop
);

  localparam int unsigned WIDTH = GROUP_W * GROUPS;

  logic [WIDTH:0] total;
  logic [WIDTH:0] nocarry;
  assign total   = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
  assign nocarry = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    p_sum_value_r1: assert (sum_o == total[WIDTH-1:0])
      else $error("R1 sum %h expected %h", sum_o, total[WIDTH-1:0]);
    p_carry_out_r2: assert (cout_o == total[WIDTH])
      else $error("R2 cout %b expected %b", cout_o, total[WIDTH]);
    p_blk_prop_r3: assert (blk_prop_o == (&(a_i ^ b_i)))
      else $error("R3 block propagate %b", blk_prop_o);
    p_blk_gen_r4: assert (blk_gen_o == nocarry[WIDTH])
      else $error("R4 block generate %b", blk_gen_o);
    p_cascade_r5: assert (cout_o == (blk_gen_o | (blk_prop_o & cin_i)))
      else $error("R5 cout does not follow block terms");
    p_grp0_cin_r7: assert (grp_cin[0] == cin_i)
      else $error("R7 group 0 carry-in differs from cin");
  end

  for (genvar k = 0; k < GROUPS; k++) begin : g_grp_chk
    logic [GROUP_W:0] own_sum;
    assign own_sum = {1'b0, a_i[k*GROUP_W +: GROUP_W]} + {1'b0, b_i[k*GROUP_W +: GROUP_W]};
    always_comb begin
      p_grp_gen_r4: assert (grp_gen[k] == own_sum[GROUP_W])
        else $error("R4 group %0d generate %b", k, grp_gen[k]);
      p_grp_prop_r3: assert (grp_prop[k] == (&(a_i[k*GROUP_W +: GROUP_W] ^ b_i[k*GROUP_W +: GROUP_W])))
        else $error("R3 group %0d propagate %b", k, grp_prop[k]);
    end
    if (k > 0) begin : g_boundary
      localparam int unsigned LW = k * GROUP_W;
      logic [LW:0] low_sum;
      assign low_sum = {1'b0, a_i[LW-1:0]} + {1'b0, b_i[LW-1:0]} + {{LW{1'b0}}, cin_i};
      always_comb begin
        p_grp_cin_r7: assert (grp_cin[k] == low_sum[LW])
          else $error("R7 carry into group %0d is %b", k, grp_cin[k]);
      end
    end
  end

endmodule

bind cla_adder_2lvl cla_adder_2lvl_chk #(.GROUP_W(GROUP_W), .GROUPS(GROUPS)) chk_i (
  .a_i       (a_i),
  .b_i       (b_i),
  .cin_i     (cin_i),
  .sum_o     (sum_o),
  .cout_o    (cout_o),
  .blk_gen_o (blk_gen_o),
  .blk_prop_o(blk_prop_o),
  .grp_cin   (grp_cin),
  .grp_gen   (grp_gen),
  .grp_prop  (grp_prop)
);

// File: tb/cla_adder_2lvl_tb_top.sv
module cla_adder_2lvl_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // Default build: four 4-bit groups
  logic [15:0] a_big, b_big, sum_big;
  logic        cin_big, cout_big, gen_big, prop_big;

  cla_adder_2lvl dut_i (
    .a_i(a_big), .b_i(b_big), .cin_i(cin_big), .sum_o(sum_big),
    .cout_o(cout_big), .blk_gen_o(gen_big), .blk_prop_o(prop_big)
  );

  // Small build: two 2-bit groups, swept exhaustively (R8)
  logic [3:0] a_sm, b_sm, sum_sm;
  logic       cin_sm, cout_sm, gen_sm, prop_sm;

  cla_adder_2lvl #(.GROUP_W(2), .GROUPS(2)) dut_small_i (
    .a_i(a_sm), .b_i(b_sm), .cin_i(cin_sm), .sum_o(sum_sm),
    .cout_o(cout_sm), .blk_gen_o(gen_sm), .blk_prop_o(prop_sm)
  );

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  task automatic evaluate(input int width, input string tag,
                          input logic [15:0] a, input logic [15:0] b, input logic c,
                          input logic [15:0] s, input logic co, input logic g, input logic p);
    logic [16:0] mask, full, plain;
    logic [15:0] exp_s;
    logic exp_co, exp_g, exp_p;
    mask   = (17'd1 << width) - 17'd1;
    full   = {1'b0, a} + {1'b0, b} + {16'd0, c};
    plain  = {1'b0, a} + {1'b0, b};
    exp_s  = full[15:0] & mask[15:0];
    exp_co = full[width];
    exp_g  = plain[width];
    exp_p  = ((a ^ b) & mask[15:0]) == mask[15:0];
    vectors++;
    if (s !== exp_s) begin
      errors++;
      $display("FAIL R1 %s a=%h b=%h cin=%b sum=%h expected %h", tag, a, b, c, s, exp_s);
    end
    if (co !== exp_co) begin
      errors++;
      $display("FAIL R2 %s a=%h b=%h cin=%b cout=%b expected %b", tag, a, b, c, co, exp_co);
    end
    if (p !== exp_p) begin
      errors++;
      $display("FAIL R3 %s a=%h b=%h prop=%b expected %b", tag, a, b, p, exp_p);
    end
    if (g !== exp_g) begin
      errors++;
      $display("FAIL R4 %s a=%h b=%h gen=%b expected %b", tag, a, b, g, exp_g);
    end
    if (co !== (g | (p & c))) begin
      errors++;
      $display("FAIL R5 %s cout=%b expected %b", tag, co, g | (p & c));
    end
  endtask

  task automatic apply_big(input string tag, input logic [15:0] a, input logic [15:0] b, input logic c);
    @(posedge clk);
    a_big = a; b_big = b; cin_big = c;
    @(negedge clk);
    evaluate(16, tag, a, b, c, sum_big, cout_big, gen_big, prop_big);
  endtask

  task automatic apply_small(input logic [3:0] a, input logic [3:0] b, input logic c);
    @(posedge clk);
    a_sm = a; b_sm = b; cin_sm = c;
    @(negedge clk);
    evaluate(4, "R8 small", {12'd0, a}, {12'd0, b}, c,
             {12'd0, sum_sm}, cout_sm, gen_sm, prop_sm);
  endtask

  initial begin
    a_big = '0; b_big = '0; cin_big = 1'b0;
    a_sm  = '0; b_sm  = '0; cin_sm  = 1'b0;

    // Idle state: zero operands give zero everywhere (R1..R4)
    apply_big("R1 zeros", 16'h0000, 16'h0000, 1'b0);

    // R6: full-width propagate chains
    apply_big("R6 ones+cin", 16'hFFFF, 16'h0000, 1'b1);
    apply_big("R6 ones+1", 16'hFFFF, 16'h0001, 1'b0);
    apply_big("R6 alt+cin", 16'hAAAA, 16'h5555, 1'b1);
    apply_big("R6 alt", 16'h5555, 16'hAAAA, 1'b0);
    apply_big("R3 comp", 16'h1234, 16'hEDCB, 1'b0);
    apply_big("R4 gen all", 16'hFFFF, 16'hFFFF, 1'b0);
    apply_big("R4 gen top", 16'h8000, 16'h8000, 1'b1);
    apply_big("R1 alt same", 16'hAAAA, 16'hAAAA, 1'b1);

    // R7: carry entering each group boundary
    for (int k = 1; k < 4; k++) begin
      apply_big("R7 boundary", 16'((32'd1 << (4 * k)) - 1), 16'h0001, 1'b0);
      apply_big("R7 boundary cin", 16'((32'd1 << (4 * k)) - 1), 16'h0000, 1'b1);
    end

    // R1/R2 random vectors
    for (int n = 0; n < 3000; n++) begin
      apply_big("R1 random", 16'($urandom), 16'($urandom), 1'($urandom));
    end

    // R8: exhaustive sweep of the 2x2-bit build
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < 2; c++) begin
          apply_small(4'(a), 4'(b), 1'(c));
        end
      end
    end

    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, cycles=%0d expected completion", cycles);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule